// File: doc/BRIEF.md
# Radio SPI Transaction Sequencer

This block sits between two requesters, one on the transmit side of a radio link and one on the receive side, and a byte-wide SPI shift engine that talks to an external 2.4 GHz radio. A requester asks for one of five access kinds: configuration register write, configuration register read, command strobe, transmit FIFO burst write or receive FIFO burst read. The sequencer then runs the whole SPI session. It frames the header byte and hands bytes to the engine one at a time, waiting for each to finish before sending the next. It streams write data in from the granted requester, streams read data out, and holds the active-low chip select low for exactly the length of the session.

The radio returns a status byte while every header byte is shifted. The sequencer latches that byte onto a status output. During a transmit FIFO burst, each byte shifted back is a fresh status byte, so the latch follows every one of them. Between sessions, chip select goes high for a guaranteed minimum time. When both requesters are waiting, a fixed priority picks one. A requester learns that its session has finished from a one-cycle acknowledge.

Top module: `radio_spi_sequencer`

## Requirements
- R1: The header byte is {bit7 = 0, bit6 = 1 for read / 0 for write, bits 5:0 = address}. Transmit FIFO writes always use address 0x3E (header 0x3E). Receive FIFO reads always use address 0x3F (header 0x7F). The request address is ignored for both FIFO kinds.
- R2: The kind codes are 0 = config write, 1 = config read, 2 = strobe, 3 = transmit FIFO write, 4 = receive FIFO read. A session is 3 bytes for kinds 0 and 1, 1 byte for a strobe (header {00, address}, for example 0x00 no-op, 0x01, 0x03, 0x04, 0x06, 0x08), and 1 + len bytes for kinds 3 and 4.
- R3: In write kinds (0, 3), each byte after the header is the granted side's wdata, and it is consumed with one wdata_take pulse per byte. In read kinds (1, 4), the bytes after the header are 0x00. The side that is not granted sees no take pulse.
- R4: In read kinds, every byte returned after the header appears on rd_data with a one-cycle rd_valid pulse, one cycle after its eng_done. Write kinds and strobes raise no rd_valid.
- R5: radio_status takes the byte returned during the header. In a transmit FIFO write it also takes every later returned byte. In a config write, the bytes returned after the header are ignored and leave radio_status unchanged.
- R6: radio_csn is low whenever eng_req is high. It stays low from the first byte of a session to the last.
- R7: Between two sessions, radio_csn stays high for at least MIN_GAP + 1 cycles.
- R8: When both sides request in the same cycle, the receive side (HI_SIDE = 1) is served first. The transmit side is served in the next session.
- R9: Each session ends with a one-cycle ack pulse to the granted side, in the cycle after the last eng_done. The two acks are never high together.
- R10: Only one byte is outstanding at a time. No eng_req is issued while an engine byte has not yet returned eng_done.
- R11: After reset, radio_csn = 1, eng_req = 0, radio_status = 0x00, and both acks and rd_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xmt_req | input | 1 | Transmit-side request, held until xmt_ack |
| xmt_kind | input | 3 | Transmit-side access kind |
| xmt_addr | input | 6 | Transmit-side register/strobe address |
| xmt_len | input | LEN_W | Transmit-side FIFO burst length in bytes |
| xmt_wdata | input | 8 | Transmit-side next write byte |
| xmt_wdata_take | output | 1 | Transmit-side write byte consumed |
| xmt_ack | output | 1 | Transmit-side session finished |
| rcv_req | input | 1 | Receive-side request, held until rcv_ack |
| rcv_kind | input | 3 | Receive-side access kind |
| rcv_addr | input | 6 | Receive-side register/strobe address |
| rcv_len | input | LEN_W | Receive-side FIFO burst length in bytes |
| rcv_wdata | input | 8 | Receive-side next write byte |
| rcv_wdata_take | output | 1 | Receive-side write byte consumed |
| rcv_ack | output | 1 | Receive-side session finished |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte from the radio |
| radio_status | output | 8 | Most recent status byte |
| eng_req | output | 1 | Request to shift one byte |
| eng_tx_byte | output | 8 | Byte to shift out |
| eng_done | input | 1 | Byte shift finished |
| eng_rx_byte | input | 8 | Byte shifted in |
| radio_csn | output | 1 | Active-low chip select |

## Verification
Two functions can land on the same cycle. One is the arbitration of two requests that rise together. The other is the close of one session while the other side is still waiting for its turn. The bench raises both requests on the same edge, both in directed cases and in random pairs. It checks that the receive side's session appears first on the engine bytes and acks first, with no transmit ack in between. It then checks that the transmit session starts only after the required chip-select gap, with its own header, data and status intact.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

    typedef enum logic [2:0] {
        KIND_CFG_WR = 3'd0,
        KIND_CFG_RD = 3'd1,
        KIND_STROBE = 3'd2,
        KIND_TXF_WR = 3'd3,
        KIND_RXF_RD = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_GAP
    } seq_state_e;

    localparam logic [5:0] ADDR_TX_FIFO = 6'h3E;
    localparam logic [5:0] ADDR_RX_FIFO = 6'h3F;
    localparam logic [7:0] DONT_CARE_BYTE = 8'h00;

    // Per-session framing decided at grant time
    typedef struct packed {
        logic [7:0] header;
        logic       is_write;
        logic       is_read;
        logic       status_each;
    } frame_info_t;

    // Register access header: bit 7 clear, bit 6 read flag, bits 5:0 address
    function automatic logic [7:0] make_header(input logic rd, input logic [5:0] addr);
        return {1'b0, rd, addr};
    endfunction

endpackage

// File: rtl/radio_seq_arbiter.sv
module radio_seq_arbiter #(
    parameter int HI_SIDE = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req,
    input  logic       enable,
    output logic       gnt_valid,
    output logic       gnt_side
);
    localparam logic HI = HI_SIDE[0];

    always_comb begin
        gnt_valid = enable && (req != 2'b00);
        gnt_side  = req[HI] ? HI : ~HI;
    end

    // R8
    gnt_req_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> req[gnt_side]);

endmodule

// File: rtl/radio_seq_framer.sv
module radio_seq_framer
    import radio_seq_pkg::*;
#(
    parameter int LEN_W = 6,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic [2:0]       kind_i,
    input  logic [5:0]       addr_i,
    input  logic [LEN_W-1:0] len_i,
    output frame_info_t      info_o,
    output logic [CNT_W-1:0] total_o
);
    always_comb begin
        info_o  = '0;
        total_o = CNT_W'(1);
        case (acc_kind_e'(kind_i))
            KIND_CFG_WR: begin
                info_o.header   = make_header(1'b0, addr_i);
                info_o.is_write = 1'b1;
                total_o         = CNT_W'(3);
            end
            KIND_CFG_RD: begin
                info_o.header  = make_header(1'b1, addr_i);
                info_o.is_read = 1'b1;
                total_o        = CNT_W'(3);
            end
            KIND_TXF_WR: begin
                info_o.header      = make_header(1'b0, ADDR_TX_FIFO);
                info_o.is_write    = 1'b1;
                info_o.status_each = 1'b1;
                total_o            = CNT_W'(len_i) + CNT_W'(1);
            end
            KIND_RXF_RD: begin
                info_o.header  = make_header(1'b1, ADDR_RX_FIFO);
                info_o.is_read = 1'b1;
                total_o        = CNT_W'(len_i) + CNT_W'(1);
            end
            default: begin
                info_o.header = make_header(1'b0, addr_i);
            end
        endcase
    end

endmodule

// File: rtl/radio_seq_ctrl.sv
module radio_seq_ctrl
    import radio_seq_pkg::*;
#(
    parameter int LEN_W   = 6,
    parameter int MIN_GAP = 2,
    localparam int CNT_W  = LEN_W + 1,
    localparam int GAP_W  = (MIN_GAP < 2) ? 1 : $clog2(MIN_GAP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gnt_valid,
    input  logic             gnt_side,
    input  frame_info_t      info_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic [7:0]       wdata0_i,
    input  logic [7:0]       wdata1_i,
    input  logic             eng_done,
    input  logic [7:0]       eng_rx_byte,
    output logic             idle_o,
    output logic             eng_req,
    output logic [7:0]       eng_tx_byte,
    output logic             csn_o,
    output logic [1:0]       take_o,
    output logic [1:0]       ack_o,
    output logic             rd_valid_o,
    output logic [7:0]       rd_data_o,
    output logic [7:0]       status_o
);
    seq_state_e       state_q;
    frame_info_t      info_q;
    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] idx_q;
    logic [GAP_W-1:0] gap_q;
    logic             side_q;
    logic             last_byte;

    assign last_byte = (idx_q == total_q - CNT_W'(1));
    assign idle_o    = (state_q == ST_IDLE);
    assign eng_req   = (state_q == ST_ISSUE);

    always_comb begin
        take_o = 2'b00;
        if (idx_q == '0) begin
            eng_tx_byte = info_q.header;
        end else if (info_q.is_write) begin
            eng_tx_byte = side_q ? wdata1_i : wdata0_i;
        end else begin
            eng_tx_byte = DONT_CARE_BYTE;
        end
        if (eng_req && idx_q != '0 && info_q.is_write) begin
            take_o[side_q] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            info_q     <= '0;
            total_q    <= '0;
            idx_q      <= '0;
            gap_q      <= '0;
            side_q     <= 1'b0;
            csn_o      <= 1'b1;
            ack_o      <= 2'b00;
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
            status_o   <= '0;
        end else begin
            ack_o      <= 2'b00;
            rd_valid_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (gnt_valid) begin
                        side_q  <= gnt_side;
                        info_q  <= info_i;
                        total_q <= total_i;
                        idx_q   <= '0;
                        csn_o   <= 1'b0;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (eng_done) begin
                        if (idx_q == '0 || info_q.status_each) begin
                            status_o <= eng_rx_byte;
                        end else if (info_q.is_read) begin
                            rd_valid_o <= 1'b1;
                            rd_data_o  <= eng_rx_byte;
                        end
                        if (last_byte) begin
                            csn_o         <= 1'b1;
                            ack_o[side_q] <= 1'b1;
                            gap_q         <= '0;
                            state_q       <= ST_GAP;
                        end else begin
                            idx_q   <= idx_q + CNT_W'(1);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: begin
                    if (gap_q == GAP_W'(MIN_GAP - 1)) begin
                        state_q <= ST_IDLE;
                    end else begin
                        gap_q <= gap_q + GAP_W'(1);
                    end
                end
            endcase
        end
    end

    // R6
    req_needs_csn_chk: assert property (@(posedge clk) disable iff (rst)
        eng_req |-> !csn_o);

    // R10
    one_byte_chk: assert property (@(posedge clk) disable iff (rst)
        eng_req |=> !eng_req);

    // R1
    hdr_bit7_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_req && idx_q == '0) |-> !eng_tx_byte[7]);

    // R7
    csn_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(csn_o) |=> csn_o);

    // R9
    ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_o));

    // R9
    ack_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_o != 2'b00) |-> $past(eng_done));

endmodule

// File: rtl/radio_spi_sequencer.sv
module radio_spi_sequencer
    import radio_seq_pkg::*;
#(
    parameter int LEN_W   = 6,
    parameter int MIN_GAP = 2,
    parameter int HI_SIDE = 1,
    localparam int CNT_W  = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xmt_req,
    input  logic [2:0]       xmt_kind,
    input  logic [5:0]       xmt_addr,
    input  logic [LEN_W-1:0] xmt_len,
    input  logic [7:0]       xmt_wdata,
    output logic             xmt_wdata_take,
    output logic             xmt_ack,
    input  logic             rcv_req,
    input  logic [2:0]       rcv_kind,
    input  logic [5:0]       rcv_addr,
    input  logic [LEN_W-1:0] rcv_len,
    input  logic [7:0]       rcv_wdata,
    output logic             rcv_wdata_take,
    output logic             rcv_ack,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic [7:0]       radio_status,
    output logic             eng_req,
    output logic [7:0]       eng_tx_byte,
    input  logic             eng_done,
    input  logic [7:0]       eng_rx_byte,
    output logic             radio_csn
);
    logic             idle;
    logic             gnt_valid;
    logic             gnt_side;
    logic [2:0]       sel_kind;
    logic [5:0]       sel_addr;
    logic [LEN_W-1:0] sel_len;
    frame_info_t      info;
    logic [CNT_W-1:0] total;
    logic [1:0]       take;
    logic [1:0]       ack;

    radio_seq_arbiter #(.HI_SIDE(HI_SIDE)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       ({rcv_req, xmt_req}),
        .enable    (idle),
        .gnt_valid (gnt_valid),
        .gnt_side  (gnt_side)
    );

    assign sel_kind = gnt_side ? rcv_kind : xmt_kind;
    assign sel_addr = gnt_side ? rcv_addr : xmt_addr;
    assign sel_len  = gnt_side ? rcv_len  : xmt_len;

    radio_seq_framer #(.LEN_W(LEN_W)) u_framer (
        .kind_i  (sel_kind),
        .addr_i  (sel_addr),
        .len_i   (sel_len),
        .info_o  (info),
        .total_o (total)
    );

    radio_seq_ctrl #(.LEN_W(LEN_W), .MIN_GAP(MIN_GAP)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .gnt_valid   (gnt_valid),
        .gnt_side    (gnt_side),
        .info_i      (info),
        .total_i     (total),
        .wdata0_i    (xmt_wdata),
        .wdata1_i    (rcv_wdata),
        .eng_done    (eng_done),
        .eng_rx_byte (eng_rx_byte),
        .idle_o      (idle),
        .eng_req     (eng_req),
        .eng_tx_byte (eng_tx_byte),
        .csn_o       (radio_csn),
        .take_o      (take),
        .ack_o       (ack),
        .rd_valid_o  (rd_valid),
        .rd_data_o   (rd_data),
        .status_o    (radio_status)
    );

    assign xmt_wdata_take = take[0];
    assign rcv_wdata_take = take[1];
    assign xmt_ack        = ack[0];
    assign rcv_ack        = ack[1];

endmodule

// File: tb/radio_spi_sequencer_bench.sv
module radio_spi_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 6;
    localparam int MIN_GAP    = 2;
    localparam int NSESS      = 128;
    localparam int NBYTE      = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xmt_req = 1'b0, rcv_req = 1'b0;
    logic [2:0] xmt_kind = '0, rcv_kind = '0;
    logic [5:0] xmt_addr = '0, rcv_addr = '0;
    logic [LEN_W-1:0] xmt_len = '0, rcv_len = '0;
    logic [7:0] xmt_wdata = '0, rcv_wdata = '0;
    logic xmt_wdata_take, rcv_wdata_take, xmt_ack, rcv_ack;
    logic rd_valid;
    logic [7:0] rd_data, radio_status, eng_tx_byte;
    logic eng_req, radio_csn;
    logic eng_done = 1'b0;
    logic [7:0] eng_rx_byte = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    radio_spi_sequencer #(.LEN_W(LEN_W), .MIN_GAP(MIN_GAP)) u_radio_spi_sequencer (
        .clk(clk), .rst(rst),
        .xmt_req(xmt_req), .xmt_kind(xmt_kind), .xmt_addr(xmt_addr), .xmt_len(xmt_len),
        .xmt_wdata(xmt_wdata), .xmt_wdata_take(xmt_wdata_take), .xmt_ack(xmt_ack),
        .rcv_req(rcv_req), .rcv_kind(rcv_kind), .rcv_addr(rcv_addr), .rcv_len(rcv_len),
        .rcv_wdata(rcv_wdata), .rcv_wdata_take(rcv_wdata_take), .rcv_ack(rcv_ack),
        .rd_valid(rd_valid), .rd_data(rd_data), .radio_status(radio_status),
        .eng_req(eng_req), .eng_tx_byte(eng_tx_byte), .eng_done(eng_done),
        .eng_rx_byte(eng_rx_byte), .radio_csn(radio_csn)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] sent_b [NSESS][NBYTE];
    int         sent_n [NSESS];
    logic [7:0] rd_b   [NSESS][NBYTE];
    int         rd_n   [NSESS];
    int sess_cnt = 0;
    int xm_wcnt = 0, rc_wcnt = 0;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic bit kind_wr(input int kind);
        return kind == 0 || kind == 3;
    endfunction
    function automatic bit kind_rd(input int kind);
        return kind == 1 || kind == 4;
    endfunction
    function automatic logic [7:0] exp_hdr(input int kind, input int addr);
        logic [5:0] a;
        a = addr[5:0];
        case (kind)
            1: return {2'b01, a};
            3: return 8'h3E;
            4: return 8'h7F;
            default: return {2'b00, a};
        endcase
    endfunction
    function automatic int exp_total(input int kind, input int len);
        case (kind)
            0, 1: return 3;
            3, 4: return len + 1;
            default: return 1;
        endcase
    endfunction
    function automatic logic [7:0] resp(input int s, input int k);
        logic [3:0] a, b;
        a = s[3:0];
        b = k[3:0];
        return 8'h5A ^ {a, b};
    endfunction
    function automatic logic [7:0] pat(input bit side, input int k);
        return side ? (8'hC0 + k[7:0]) : (8'h30 + k[7:0]);
    endfunction

    // Engine model and session monitor, all sampled on the falling edge
    initial begin
        bit   busy = 0;
        bit   csn_was_high = 1;
        int   lat = 0, hi_cnt = 0, idx_cnt = 0, rs = 0, rk = 0;
        for (int i = 0; i < NSESS; i++) begin
            sent_n[i] = 0;
            rd_n[i]   = 0;
        end
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (!rst) begin
                if (!radio_csn && csn_was_high) begin
                    // R7: chip select high time between sessions
                    if (sess_cnt > 0) chk(hi_cnt >= MIN_GAP + 1, "R7", "csn high cycles", hi_cnt, MIN_GAP + 1);
                    sess_cnt++;
                    idx_cnt = 0;
                end
                if (radio_csn) hi_cnt++; else hi_cnt = 0;
                csn_was_high = radio_csn;
                if (busy) begin
                    if (eng_req) chk(1'b0, "R10", "request while byte outstanding", 1, 0);
                    if (lat == 0) begin
                        eng_rx_byte = resp(rs, rk);
                        eng_done    = 1'b1;
                        busy        = 0;
                    end else begin
                        lat--;
                    end
                end else if (eng_req) begin
                    if (radio_csn) chk(1'b0, "R6", "csn during byte", 1, 0);
                    rs = sess_cnt - 1;
                    rk = idx_cnt;
                    if (rs >= 0 && rs < NSESS && idx_cnt < NBYTE) sent_b[rs][idx_cnt] = eng_tx_byte;
                    idx_cnt++;
                    if (rs >= 0 && rs < NSESS) sent_n[rs] = idx_cnt;
                    busy = 1;
                    lat  = $urandom % 3;
                end
                if (rd_valid) begin
                    rs = sess_cnt - 1;
                    if (rs >= 0 && rs < NSESS) begin
                        if (rd_n[rs] < NBYTE) rd_b[rs][rd_n[rs]] = rd_data;
                        rd_n[rs]++;
                    end
                end
                if (xmt_wdata_take) begin
                    xm_wcnt++;
                    xmt_wdata = pat(1'b0, xm_wcnt);
                end
                if (rcv_wdata_take) begin
                    rc_wcnt++;
                    rcv_wdata = pat(1'b1, rc_wcnt);
                end
            end
        end
    end

    task automatic setup(input bit side, input int kind, input int addr, input int len);
        if (side) begin
            rcv_kind = kind[2:0]; rcv_addr = addr[5:0]; rcv_len = len[LEN_W-1:0];
            rc_wcnt = 0; rcv_wdata = pat(1'b1, 0);
        end else begin
            xmt_kind = kind[2:0]; xmt_addr = addr[5:0]; xmt_len = len[LEN_W-1:0];
            xm_wcnt = 0; xmt_wdata = pat(1'b0, 0);
        end
    endtask

    task automatic check_txn(input int s, input bit side, input int kind, input int addr, input int len);
        int tot, nr, wc;
        logic [7:0] e;
        tot = exp_total(kind, len);
        if (s >= NSESS) return;
        chk(sent_n[s] == tot, "R2", "session byte count", sent_n[s], tot);
        chk(sent_b[s][0] == exp_hdr(kind, addr), "R1", "header byte", sent_b[s][0], exp_hdr(kind, addr));
        for (int k = 1; k < tot && k < NBYTE; k++) begin
            e = kind_wr(kind) ? pat(side, k - 1) : 8'h00;
            chk(sent_b[s][k] == e, "R3", "body byte", sent_b[s][k], e);
        end
        wc = side ? rc_wcnt : xm_wcnt;
        chk(wc == (kind_wr(kind) ? tot - 1 : 0), "R3", "wdata take count", wc, kind_wr(kind) ? tot - 1 : 0);
        nr = kind_rd(kind) ? tot - 1 : 0;
        chk(rd_n[s] == nr, "R4", "read byte count", rd_n[s], nr);
        for (int k = 0; k < nr && k < NBYTE; k++)
            chk(rd_b[s][k] == resp(s, k + 1), "R4", "read byte", rd_b[s][k], resp(s, k + 1));
        e = (kind == 3) ? resp(s, tot - 1) : resp(s, 0);
        chk(radio_status == e, "R5", "status byte", radio_status, e);
        chk(!xmt_ack && !rcv_ack, "R9", "ack width", {xmt_ack, rcv_ack}, 0);
    endtask

    task automatic wait_ack(input bit side, output bit other_first);
        other_first = 0;
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (xmt_ack && rcv_ack) chk(1'b0, "R9", "both acks high", 3, 1);
            if ((side ? xmt_ack : rcv_ack)) other_first = 1;
            if (side ? rcv_ack : xmt_ack) break;
        end
        if (side) rcv_req = 1'b0; else xmt_req = 1'b0;
    endtask

    task automatic run_one(input bit side, input int kind, input int addr, input int len);
        int s;
        bit of;
        s = sess_cnt;
        setup(side, kind, addr, len);
        if (side) rcv_req = 1'b1; else xmt_req = 1'b1;
        wait_ack(side, of);
        @(negedge clk);
        check_txn(s, side, kind, addr, len);
    endtask

    task automatic run_pair(input int kx, input int ax, input int lx, input int kr, input int ar, input int lr);
        int s;
        bit of;
        s = sess_cnt;
        setup(1'b0, kx, ax, lx);
        setup(1'b1, kr, ar, lr);
        xmt_req = 1'b1;
        rcv_req = 1'b1;
        wait_ack(1'b1, of);
        // R8: receive side must finish before the transmit side acks
        chk(!of, "R8", "transmit acked before receive", of, 0);
        @(negedge clk);
        check_txn(s, 1'b1, kr, ar, lr);
        wait_ack(1'b0, of);
        @(negedge clk);
        check_txn(s + 1, 1'b0, kx, ax, lx);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        chk(1'b0, "R9", "watchdog, session never completed", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(radio_csn == 1'b1, "R11", "csn after reset", radio_csn, 1);
        chk(eng_req == 1'b0, "R11", "eng_req after reset", eng_req, 0);
        chk(radio_status == 8'h00, "R11", "status after reset", radio_status, 0);
        chk(!xmt_ack && !rcv_ack && !rd_valid, "R11", "pulses after reset", {xmt_ack, rcv_ack, rd_valid}, 0);

        // Directed strobes, including the no-op status fetch (R2)
        run_one(1'b0, 2, 6'h00, 0);
        run_one(1'b0, 2, 6'h01, 0);
        run_one(1'b1, 2, 6'h03, 0);
        run_one(1'b0, 2, 6'h04, 0);
        run_one(1'b1, 2, 6'h06, 0);
        run_one(1'b1, 2, 6'h08, 0);
        // Config write ignores returned bytes (R5), config read returns two (R4)
        run_one(1'b0, 0, 6'h11, 0);
        run_one(1'b1, 1, 6'h18, 0);
        // FIFO bursts: empty, single, long; address input ignored (R1)
        run_one(1'b0, 3, 6'h05, 0);
        run_one(1'b0, 3, 6'h2A, 1);
        run_one(1'b0, 3, 6'h00, 16);
        run_one(1'b1, 4, 6'h12, 16);
        run_one(1'b1, 4, 6'h3E, 1);
        // Simultaneous requests (R8)
        run_pair(3, 6'h00, 4, 4, 6'h00, 3);
        run_pair(0, 6'h1C, 0, 2, 6'h08, 0);

        for (int i = 0; i < 50; i++) begin
            int k, a, l;
            bit sd;
            k  = $urandom % 5;
            a  = $urandom % 64;
            l  = $urandom % 9;
            sd = $urandom % 2;
            if (i % 6 == 5) run_pair(k, a, l, $urandom % 5, $urandom % 64, $urandom % 9);
            else run_one(sd, k, a, l);
        end

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule